// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder and Register Checker

This block takes a 32-bit floating-point operate instruction word, qualified by a valid strobe, and turns it into a decoded description one clock later. The description holds the 9-bit operation code, the three register numbers, and a size code for each operand slot (none, single, double or quad). It also carries, per slot, a flag telling whether that operand moves as a raw bit pattern rather than as an unpacked floating-point value. Integer sources and destinations of conversions and the plain sign and move operations use this raw form.

Alongside the decode, the block checks the register numbers against the operand sizes. Doubles need even registers and quads need registers that are multiples of four. For compare operations the destination is the condition code, so the destination field must be zero. Any violation produces trap code 6, and the instruction is reported as not executable. An operation code that belongs to neither table leaves the recognised flag low and the trap code at zero. A later stage can then raise its own unimplemented-operation trap. The block does no arithmetic and does not touch a register file.

Top module: `fpop_decode_chk`

## Requirements
- R1: While reset is asserted, and after it, until the first valid strobe, every output is zero.
- R2: One clock after a valid strobe, `dec_opf` holds word bits 13:5, `reg_src1` bits 18:14, `reg_src2` bits 4:0 and `reg_dst` bits 29:25, whether or not the word is recognised.
- R3: A word whose value ANDed with 0xC1F80000 equals 0x81A00000 belongs to the arithmetic group, and one whose masked value equals 0x81A80000 belongs to the compare group. Any other word is unrecognised (`dec_known`=0, `trap_code`=0, `exec_ok`=0).
- R4: Size codes are 0 none, 1 single, 2 double, 3 quad. In the arithmetic group, opf 0x041/0x045/0x049/0x04D give size 1 on all three slots, 0x042/0x046/0x04A/0x04E give size 2 and 0x043/0x047/0x04B/0x04F give size 3. Square root 0x029/0x02A/0x02B gives src1 size 0 and sizes 1/2/3 on src2 and dst. All raw flags are 0 for these.
- R5: Conversions in the arithmetic group set src1 size 0 and these src2/dst sizes. Integer to float: 0x0C4 1/1, 0x0C8 1/2, 0x0CC 1/3, each with `raw_src2`=1. Float to integer: 0x0D1 1/1, 0x0D2 2/1, 0x0D3 3/1, each with `raw_dst`=1. Float to float: 0x0C6 2/1, 0x0C7 3/1, 0x0C9 1/2, 0x0CB 3/2, 0x0CD 1/3, 0x0CE 2/3. The widening multiplies 0x069 and 0x06E give sources 1/1 with dst 2, and sources 2/2 with dst 3.
- R6: Move, negate and absolute (opf 0x001, 0x005, 0x009) give src1 size 0, src2 and dst size 1, with `raw_src2`=1 and `raw_dst`=1.
- R7: In the compare group, opf 0x051/0x055 give size 1 on both sources, 0x052/0x056 size 2 and 0x053/0x057 size 3. The dst size is 0 and all raw flags are 0.
- R8: An opf absent from its group's table gives `dec_known`=0, all sizes and raw flags 0, `trap_code`=0 and `exec_ok`=0.
- R9: For a recognised word, a size-2 slot with an odd register number, or a size-3 slot whose register number has a nonzero low two bits, sets `trap_code`=6 and `exec_ok`=0.
- R10: A recognised compare whose rd field is nonzero sets `trap_code`=6 and `exec_ok`=0.
- R11: While the valid strobe is low, every output holds its value.
- R12: `exec_ok` is 1 exactly when the word is recognised and no register violation is found, and in that case `trap_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_word | input | 32 | Instruction word |
| dec_known | output | 1 | Word matched a group and a table entry |
| dec_opf | output | 9 | Operation code field |
| sz_src1 | output | 2 | Size code of source 1 |
| sz_src2 | output | 2 | Size code of source 2 |
| sz_dst | output | 2 | Size code of destination (0 for condition code) |
| raw_src1 | output | 1 | Source 1 is moved as raw bits |
| raw_src2 | output | 1 | Source 2 is moved as raw bits |
| raw_dst | output | 1 | Destination is written as raw bits |
| reg_src1 | output | 5 | Source 1 register number |
| reg_src2 | output | 5 | Source 2 register number |
| reg_dst | output | 5 | Destination register number |
| trap_code | output | 3 | 0 for no trap, 6 for invalid register |
| exec_ok | output | 1 | Instruction may be executed |

## Verification
Every decoded field, the trap code and the execute flag are registered together, so all of them are due at the first rising edge after the strobe. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after that rising edge. The sweep covers both groups, every 9-bit opf value and five register patterns. The patterns are chosen to hit aligned operands, odd registers, quad misalignment and a nonzero compare destination. The hold behaviour is read back several cycles after the strobe drops, while the word input is deliberately changed.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int WORD_W  = 32;
    localparam int OPF_W   = 9;
    localparam int REG_W   = 5;
    localparam int NOPS    = 3;

    localparam int OPF_LSB = 5;
    localparam int RS1_LSB = 14;
    localparam int RS2_LSB = 0;
    localparam int RD_LSB  = 25;

    localparam logic [WORD_W-1:0] GRP_MASK  = 32'hC1F8_0000;
    localparam logic [WORD_W-1:0] GRP_ARITH = 32'h81A0_0000;
    localparam logic [WORD_W-1:0] GRP_CMP   = 32'h81A8_0000;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_S    = 2'd1,
        SZ_D    = 2'd2,
        SZ_Q    = 2'd3
    } fpd_size_e;

    typedef struct packed {
        logic      known;
        fpd_size_e sz_a;
        logic      raw_a;
        fpd_size_e sz_b;
        logic      raw_b;
        fpd_size_e sz_d;
        logic      raw_d;
    } fpd_shape_t;

    function automatic fpd_shape_t fpd_mk(fpd_size_e a, logic ra,
                                          fpd_size_e b, logic rb,
                                          fpd_size_e d, logic rd);
        fpd_shape_t s;
        s.known = 1'b1;
        s.sz_a  = a;
        s.raw_a = ra;
        s.sz_b  = b;
        s.raw_b = rb;
        s.sz_d  = d;
        s.raw_d = rd;
        return s;
    endfunction

endpackage

// File: rtl/fpd_opf_table.sv
module fpd_opf_table
    import fpd_pkg::*;
(
    input  logic             arith_hit,
    input  logic             cmp_hit,
    input  logic [OPF_W-1:0] opf,
    output fpd_shape_t       shape
);

    always_comb begin
        shape = '0;
        if (arith_hit) begin
            unique case (opf)
                9'h041, 9'h045, 9'h049, 9'h04D: shape = fpd_mk(SZ_S, 1'b0, SZ_S, 1'b0, SZ_S, 1'b0);
                9'h042, 9'h046, 9'h04A, 9'h04E: shape = fpd_mk(SZ_D, 1'b0, SZ_D, 1'b0, SZ_D, 1'b0);
                9'h043, 9'h047, 9'h04B, 9'h04F: shape = fpd_mk(SZ_Q, 1'b0, SZ_Q, 1'b0, SZ_Q, 1'b0);
                9'h029: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b0, SZ_S, 1'b0);
                9'h02A: shape = fpd_mk(SZ_NONE, 1'b0, SZ_D, 1'b0, SZ_D, 1'b0);
                9'h02B: shape = fpd_mk(SZ_NONE, 1'b0, SZ_Q, 1'b0, SZ_Q, 1'b0);
                9'h001, 9'h005, 9'h009:
                        shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b1, SZ_S, 1'b1);
                9'h069: shape = fpd_mk(SZ_S, 1'b0, SZ_S, 1'b0, SZ_D, 1'b0);
                9'h06E: shape = fpd_mk(SZ_D, 1'b0, SZ_D, 1'b0, SZ_Q, 1'b0);
                9'h0C4: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b1, SZ_S, 1'b0);
                9'h0C8: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b1, SZ_D, 1'b0);
                9'h0CC: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b1, SZ_Q, 1'b0);
                9'h0D1: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b0, SZ_S, 1'b1);
                9'h0D2: shape = fpd_mk(SZ_NONE, 1'b0, SZ_D, 1'b0, SZ_S, 1'b1);
                9'h0D3: shape = fpd_mk(SZ_NONE, 1'b0, SZ_Q, 1'b0, SZ_S, 1'b1);
                9'h0C6: shape = fpd_mk(SZ_NONE, 1'b0, SZ_D, 1'b0, SZ_S, 1'b0);
                9'h0C7: shape = fpd_mk(SZ_NONE, 1'b0, SZ_Q, 1'b0, SZ_S, 1'b0);
                9'h0C9: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b0, SZ_D, 1'b0);
                9'h0CB: shape = fpd_mk(SZ_NONE, 1'b0, SZ_Q, 1'b0, SZ_D, 1'b0);
                9'h0CD: shape = fpd_mk(SZ_NONE, 1'b0, SZ_S, 1'b0, SZ_Q, 1'b0);
                9'h0CE: shape = fpd_mk(SZ_NONE, 1'b0, SZ_D, 1'b0, SZ_Q, 1'b0);
                default: shape = '0;
            endcase
        end else if (cmp_hit) begin
            unique case (opf)
                9'h051, 9'h055: shape = fpd_mk(SZ_S, 1'b0, SZ_S, 1'b0, SZ_NONE, 1'b0);
                9'h052, 9'h056: shape = fpd_mk(SZ_D, 1'b0, SZ_D, 1'b0, SZ_NONE, 1'b0);
                9'h053, 9'h057: shape = fpd_mk(SZ_Q, 1'b0, SZ_Q, 1'b0, SZ_NONE, 1'b0);
                default: shape = '0;
            endcase
        end
    end

endmodule

// File: rtl/fpd_reg_align.sv
module fpd_reg_align
    import fpd_pkg::*;
#(
    parameter bit ZERO_IF_NONE = 1'b0
) (
    input  logic             en,
    input  fpd_size_e        size,
    input  logic [REG_W-1:0] idx,
    output logic             bad
);

    always_comb begin
        bad = 1'b0;
        if (en) begin
            unique case (size)
                SZ_Q:    bad = (idx[1:0] != 2'b00);
                SZ_D:    bad = idx[0];
                SZ_NONE: bad = ZERO_IF_NONE && (idx != '0);
                default: bad = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fpop_decode_chk.sv
module fpop_decode_chk
    import fpd_pkg::*;
#(
    parameter int TRAP_W      = 3,
    parameter int BADREG_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              dec_known,
    output logic [OPF_W-1:0]  dec_opf,
    output logic [1:0]        sz_src1,
    output logic [1:0]        sz_src2,
    output logic [1:0]        sz_dst,
    output logic              raw_src1,
    output logic              raw_src2,
    output logic              raw_dst,
    output logic [REG_W-1:0]  reg_src1,
    output logic [REG_W-1:0]  reg_src2,
    output logic [REG_W-1:0]  reg_dst,
    output logic [TRAP_W-1:0] trap_code,
    output logic              exec_ok
);

    typedef struct packed {
        fpd_shape_t         shape;
        logic [OPF_W-1:0]   opf;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic [REG_W-1:0]   rd;
        logic [TRAP_W-1:0]  trap;
        logic               exec_ok;
    } dec_out_t;

    logic [WORD_W-1:0] masked;
    logic              arith_hit;
    logic              cmp_hit;
    logic [OPF_W-1:0]  opf_f;
    logic [REG_W-1:0]  idx_arr [NOPS];
    fpd_size_e         sz_arr  [NOPS];
    logic [NOPS-1:0]   bad_vec;
    fpd_shape_t        shape;
    dec_out_t          out_d;
    dec_out_t          out_q;

    assign masked    = in_word & GRP_MASK;
    assign arith_hit = (masked == GRP_ARITH);
    assign cmp_hit   = (masked == GRP_CMP);
    assign opf_f     = in_word[OPF_LSB +: OPF_W];

    fpd_opf_table u_table (
        .arith_hit (arith_hit),
        .cmp_hit   (cmp_hit),
        .opf       (opf_f),
        .shape     (shape)
    );

    always_comb begin
        idx_arr[0] = in_word[RS1_LSB +: REG_W];
        idx_arr[1] = in_word[RS2_LSB +: REG_W];
        idx_arr[2] = in_word[RD_LSB  +: REG_W];
        sz_arr[0]  = shape.sz_a;
        sz_arr[1]  = shape.sz_b;
        sz_arr[2]  = shape.sz_d;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        fpd_reg_align #(
            .ZERO_IF_NONE (g == NOPS - 1)
        ) u_align (
            .en   (shape.known),
            .size (sz_arr[g]),
            .idx  (idx_arr[g]),
            .bad  (bad_vec[g])
        );
    end

    always_comb begin
        out_d = out_q;
        if (in_valid) begin
            out_d.shape   = shape;
            out_d.opf     = opf_f;
            out_d.rs1     = idx_arr[0];
            out_d.rs2     = idx_arr[1];
            out_d.rd      = idx_arr[2];
            out_d.trap    = (|bad_vec) ? TRAP_W'(BADREG_CODE) : '0;
            out_d.exec_ok = shape.known && !(|bad_vec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_known = out_q.shape.known;
    assign dec_opf   = out_q.opf;
    assign sz_src1   = out_q.shape.sz_a;
    assign sz_src2   = out_q.shape.sz_b;
    assign sz_dst    = out_q.shape.sz_d;
    assign raw_src1  = out_q.shape.raw_a;
    assign raw_src2  = out_q.shape.raw_b;
    assign raw_dst   = out_q.shape.raw_d;
    assign reg_src1  = out_q.rs1;
    assign reg_src2  = out_q.rs2;
    assign reg_dst   = out_q.rd;
    assign trap_code = out_q.trap;
    assign exec_ok   = out_q.exec_ok;

endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
    parameter int TRAP_W      = 3,
    parameter int BADREG_CODE = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       in_word,
    input logic              dec_known,
    input logic [8:0]        dec_opf,
    input logic [1:0]        sz_src1,
    input logic [1:0]        sz_src2,
    input logic [1:0]        sz_dst,
    input logic              raw_src1,
    input logic              raw_src2,
    input logic              raw_dst,
    input logic [4:0]        reg_src1,
    input logic [4:0]        reg_src2,
    input logic [4:0]        reg_dst,
    input logic [TRAP_W-1:0] trap_code,
    input logic              exec_ok
);

    logic foreign;
    assign foreign = ((in_word & 32'hC1F8_0000) != 32'h81A0_0000) &&
                     ((in_word & 32'hC1F8_0000) != 32'h81A8_0000);

    p_field_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dec_opf == $past(in_word[13:5])) &&
                     (reg_src1 == $past(in_word[18:14])) &&
                     (reg_src2 == $past(in_word[4:0])) &&
                     (reg_dst == $past(in_word[29:25])));

    p_foreign_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && foreign |=> !dec_known && !exec_ok && (trap_code == '0));

    p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_known |-> (trap_code == '0) && (sz_src1 == 2'd0) && (sz_src2 == 2'd0) &&
                       (sz_dst == 2'd0) && !raw_src1 && !raw_src2 && !raw_dst);

    p_quad_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_known && (sz_dst == 2'd3) && (reg_dst[1:0] != 2'b00)
        |-> (trap_code == TRAP_W'(BADREG_CODE)) && !exec_ok);

    p_dbl_src1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_known && (sz_src1 == 2'd2) && reg_src1[0]
        |-> (trap_code == TRAP_W'(BADREG_CODE)) && !exec_ok);

    p_cmp_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_known && (sz_dst == 2'd0) && (reg_dst != 5'd0)
        |-> (trap_code == TRAP_W'(BADREG_CODE)) && !exec_ok);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dec_known) && $stable(dec_opf) && $stable(sz_src1) &&
                      $stable(sz_src2) && $stable(sz_dst) && $stable(raw_src1) &&
                      $stable(raw_src2) && $stable(raw_dst) && $stable(reg_src1) &&
                      $stable(reg_src2) && $stable(reg_dst) && $stable(trap_code) &&
                      $stable(exec_ok));

    p_exec_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_ok |-> dec_known && (trap_code == '0));

endmodule

bind fpop_decode_chk fpd_checker #(
    .TRAP_W      (TRAP_W),
    .BADREG_CODE (BADREG_CODE)
) u_fpd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .dec_known (dec_known),
    .dec_opf   (dec_opf),
    .sz_src1   (sz_src1),
    .sz_src2   (sz_src2),
    .sz_dst    (sz_dst),
    .raw_src1  (raw_src1),
    .raw_src2  (raw_src2),
    .raw_dst   (raw_dst),
    .reg_src1  (reg_src1),
    .reg_src2  (reg_src2),
    .reg_dst   (reg_dst),
    .trap_code (trap_code),
    .exec_ok   (exec_ok)
);

// File: tb/test_fpop_decode_chk.sv
`timescale 1ns/1ps
module test_fpop_decode_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        dec_known;
    logic [8:0]  dec_opf;
    logic [1:0]  sz_src1, sz_src2, sz_dst;
    logic        raw_src1, raw_src2, raw_dst;
    logic [4:0]  reg_src1, reg_src2, reg_dst;
    logic [2:0]  trap_code;
    logic        exec_ok;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpop_decode_chk i_fpop_decode_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .dec_known(dec_known), .dec_opf(dec_opf),
        .sz_src1(sz_src1), .sz_src2(sz_src2), .sz_dst(sz_dst),
        .raw_src1(raw_src1), .raw_src2(raw_src2), .raw_dst(raw_dst),
        .reg_src1(reg_src1), .reg_src2(reg_src2), .reg_dst(reg_dst),
        .trap_code(trap_code), .exec_ok(exec_ok)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // {known, sz1, raw1, sz2, raw2, szd, rawd}
    function automatic logic [9:0] mk(int a, bit ra, int b, bit rb, int d, bit rd);
        return {1'b1, 2'(a), ra, 2'(b), rb, 2'(d), rd};
    endfunction

    function automatic logic [9:0] ref_shape(bit cmp, int op);
        if (cmp) begin
            case (op)
                'h51, 'h55: return mk(1, 0, 1, 0, 0, 0);
                'h52, 'h56: return mk(2, 0, 2, 0, 0, 0);
                'h53, 'h57: return mk(3, 0, 3, 0, 0, 0);
                default:    return '0;
            endcase
        end
        case (op)
            'h41, 'h45, 'h49, 'h4D: return mk(1, 0, 1, 0, 1, 0);
            'h42, 'h46, 'h4A, 'h4E: return mk(2, 0, 2, 0, 2, 0);
            'h43, 'h47, 'h4B, 'h4F: return mk(3, 0, 3, 0, 3, 0);
            'h29: return mk(0, 0, 1, 0, 1, 0);
            'h2A: return mk(0, 0, 2, 0, 2, 0);
            'h2B: return mk(0, 0, 3, 0, 3, 0);
            'h01, 'h05, 'h09: return mk(0, 0, 1, 1, 1, 1);
            'h69: return mk(1, 0, 1, 0, 2, 0);
            'h6E: return mk(2, 0, 2, 0, 3, 0);
            'hC4: return mk(0, 0, 1, 1, 1, 0);
            'hC8: return mk(0, 0, 1, 1, 2, 0);
            'hCC: return mk(0, 0, 1, 1, 3, 0);
            'hD1: return mk(0, 0, 1, 0, 1, 1);
            'hD2: return mk(0, 0, 2, 0, 1, 1);
            'hD3: return mk(0, 0, 3, 0, 1, 1);
            'hC6: return mk(0, 0, 2, 0, 1, 0);
            'hC7: return mk(0, 0, 3, 0, 1, 0);
            'hC9: return mk(0, 0, 1, 0, 2, 0);
            'hCB: return mk(0, 0, 3, 0, 2, 0);
            'hCD: return mk(0, 0, 1, 0, 3, 0);
            'hCE: return mk(0, 0, 2, 0, 3, 0);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(bit cmp, int op, bit known);
        if (!known) return "R8";
        if (cmp) return "R7";
        if (op == 'h01 || op == 'h05 || op == 'h09) return "R6";
        if (op >= 'h60) return "R5";
        return "R4";
    endfunction

    function automatic bit misfit(int sz, int idx);
        if (sz == 3) return (idx % 4) != 0;
        if (sz == 2) return (idx % 2) != 0;
        return 1'b0;
    endfunction

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_all(input string tag, input logic [9:0] sh,
                             input logic [8:0] op, input logic [4:0] r1,
                             input logic [4:0] r2, input logic [4:0] rd,
                             input logic [2:0] tr, input bit ex, input string rtrap);
        check("R2", "opf", 32'(dec_opf), 32'(op));
        check("R2", "regs", {17'd0, reg_src1, reg_src2, reg_dst}, {17'd0, r1, r2, rd});
        check(tag, "known", 32'(dec_known), 32'(sh[9]));
        check(tag, "sizes", {26'd0, sz_src1, sz_src2, sz_dst}, {26'd0, sh[8:7], sh[5:4], sh[2:1]});
        check(tag, "raw", {29'd0, raw_src1, raw_src2, raw_dst}, {29'd0, sh[6], sh[3], sh[0]});
        check(rtrap, "trap", 32'(trap_code), 32'(tr));
        check("R12", "exec_ok", 32'(exec_ok), 32'(ex));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [9:0] sh;
        logic [31:0] w;
        bit bad;
        int rs1, rs2, rd;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset",
              {dec_known, dec_opf, sz_src1, sz_src2, sz_dst, raw_src1, raw_src2, raw_dst, exec_ok, trap_code},
              '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "outputs after reset",
              {dec_known, dec_opf, sz_src1, sz_src2, sz_dst, raw_src1, raw_src2, raw_dst, exec_ok, trap_code},
              '0);
        check("R1", "regs after reset", {17'd0, reg_src1, reg_src2, reg_dst}, '0);

        // R3..R10: sweep both groups, every opf, five register patterns
        for (int g = 0; g < 2; g++) begin
            for (int op = 0; op < 512; op++) begin
                for (int p = 0; p < 5; p++) begin
                    case (p)
                        0: begin rs1 = 0;  rs2 = 4;  rd = 8;  end
                        1: begin rs1 = 1;  rs2 = 0;  rd = 0;  end
                        2: begin rs1 = 4;  rs2 = 2;  rd = 0;  end
                        3: begin rs1 = 8;  rs2 = 12; rd = 6;  end
                        default: begin rs1 = 2; rs2 = 6; rd = 16; end
                    endcase
                    w = {2'b10, 5'(rd), (g == 1) ? 6'h35 : 6'h34, 5'(rs1), 9'(op), 5'(rs2)};
                    apply(w);
                    sh = ref_shape(g == 1, op);
                    bad = sh[9] && (misfit(sh[8:7], rs1) || misfit(sh[5:4], rs2) ||
                          ((sh[2:1] == 0) ? (rd != 0) : misfit(sh[2:1], rd)));
                    check_all(req_of(g == 1, op, sh[9]), sh, 9'(op), 5'(rs1), 5'(rs2), 5'(rd),
                              bad ? 3'd6 : 3'd0, sh[9] && !bad,
                              (g == 1 && sh[9] && rd != 0) ? "R10" : (sh[9] ? "R9" : "R8"));
                end
            end
        end

        // R3: words outside both groups, carrying otherwise valid opf codes
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: w = 32'hC1A0_0820;   // top bits 11
                1: w = 32'h81B0_0820;   // neighbouring op field
                2: w = 32'h01A0_0820;   // top bits 00
                default: w = 32'h81B8_0A20;
            endcase
            apply(w);
            check("R3", "known outside groups", 32'(dec_known), 0);
            check("R3", "trap outside groups", 32'(trap_code), 0);
            check("R3", "exec outside groups", 32'(exec_ok), 0);
            check("R3", "opf still captured", 32'(dec_opf), 32'(w[13:5]));
        end

        // R11: hold while strobe is low
        apply({2'b10, 5'd2, 6'h34, 5'd4, 9'h04B, 5'd8});
        in_word = 32'h81A8_0A20;
        repeat (4) @(negedge clk);
        check("R11", "hold known/sizes", {29'd0, dec_known, sz_dst}, {29'd0, 1'b1, 2'd3});
        check("R11", "hold trap/exec", {28'd0, trap_code, exec_ok}, {28'd0, 3'd6, 1'b0});
        check("R11", "hold regs", {17'd0, reg_src1, reg_src2, reg_dst}, {17'd0, 5'd4, 5'd8, 5'd2});

        // R1: reset returns outputs to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "outputs on second reset",
              {dec_known, dec_opf, sz_dst, reg_dst, trap_code, exec_ok}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule